// File: doc/BRIEF.md
# Synchronous Serial Position Transmitter (Sensor Side)

This block is the sensor end of a synchronous serial position link. A controller drives a clock line that idles high. The block watches that line from its own fast system clock. On the first falling edge after idle, it captures the parallel position word. On each rising edge after that, it puts the next bit of the word on a single data line, starting with the most significant bit.

A retriggerable monoflop timer, counted in system clock cycles, governs the frame. Every controller clock edge reloads it. When it runs out, the block re-arms, the data line returns high, and the next falling edge captures a fresh word. If the controller stops clocking partway through a frame for longer than the monoflop period, the frame is abandoned. Once the last bit has gone out, the transmitter ignores further clocking until it has re-armed.

The controller clock enters through a two-stage synchronizer, and its edges are detected in the system clock domain. Each detected edge takes effect on the data line three system clock edges after the pin changes.

Top module: `ssi_tx`

## Requirements
- R1: After reset, and whenever the block is armed (idle or re-armed), `dataOut` is 1.
- R2: The first falling edge of `ctrlClkIn` seen while armed captures `posWord`. Later changes of `posWord` do not alter the bits of that frame. `dataOut` stays 1 until the first rising edge.
- R3: Rising edge k of a frame (k = 1..WORD_W) drives bit WORD_W-k of the captured word on `dataOut`, so the MSB goes first and bit 0 goes last. The bit appears three system clock edges after the pin rises, and `dataOut` changes only after a detected rising edge or on re-arm.
- R4: Rising edge WORD_W+1 ends the frame. `dataOut` then goes to 0 when HOLD_LAST = 0, or keeps bit 0 when HOLD_LAST = 1, until re-arm.
- R5: Every detected edge reloads the monoflop. A frame whose edges are never more than MONO_CYC system cycles apart completes intact.
- R6: If MONO_CYC system cycles pass with no detected edge in the middle of a frame, the frame aborts, `dataOut` returns to 1, and the next falling edge captures a fresh word.
- R7: After the frame has ended and before the monoflop expires, further edges start no new frame and leave `dataOut` at its end-of-frame value. They also retrigger the monoflop.
- R8: When the monoflop expires after a completed frame, `dataOut` returns to 1, and the next falling edge starts a new frame with the word present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlClkIn | input | 1 | Controller clock, asynchronous, idles high |
| posWord | input | WORD_W | Parallel position word from the sensor core |
| dataOut | output | 1 | Serial data line to the controller |

## Verification
The bench changes `posWord` right after each capture. A design that latched continuously, or latched on the wrong edge, would send a mix of the old and new words. It stretches one clock half-period to just under the monoflop period to catch a timer that expires too early, and it stalls a frame beyond that period to catch one that never aborts or that fails to re-arm. After a frame ends, it sends extra pulses before expiry, which a design lacking the post-frame lockout would answer with a new frame. Two instances cover both end-of-frame line options, and a per-cycle reference model exposes any off-by-one in the bit count or the synchronizer latency.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } ssiState_t;

  typedef struct packed {
    logic latch;
    logic shift;
    logic park;
    logic rearm;
  } ssiStrb_t;

endpackage

// File: rtl/ssi_tx_sync.sv
module ssi_tx_sync (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseDet,
  output logic fallDet
);

  logic stageA;
  logic stageB;
  logic stageC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA <= 1'b1;
      stageB <= 1'b1;
      stageC <= 1'b1;
    end else begin
      stageA <= asyncIn;
      stageB <= stageA;
      stageC <= stageB;
    end
  end

  assign riseDet = stageB & ~stageC;
  assign fallDet = ~stageB & stageC;

endmodule

// File: rtl/ssi_tx_ctrl.sv
module ssi_tx_ctrl
  import ssi_tx_pkg::*;
#(
  parameter int WORD_W   = 25,
  parameter int MONO_CYC = 4000,
  localparam int CNT_W   = $clog2(WORD_W + 1),
  localparam int MONO_W  = $clog2(MONO_CYC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              riseDet,
  input  logic              fallDet,
  output ssiStrb_t          strb,
  output logic              armed,
  output logic              done,
  output logic [MONO_W-1:0] monoCnt
);

  localparam logic [CNT_W-1:0]  LAST_RISE = CNT_W'(WORD_W);
  localparam logic [MONO_W-1:0] MONO_LOAD = MONO_W'(MONO_CYC - 1);

  ssiState_t        state;
  logic [CNT_W-1:0] riseCnt;
  logic             edgeDet;
  logic             monoZero;

  assign edgeDet  = riseDet | fallDet;
  assign monoZero = (monoCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ARMED;
      monoCnt <= '0;
      riseCnt <= '0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (fallDet) begin
            state   <= ST_SHIFT;
            monoCnt <= MONO_LOAD;
            riseCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (edgeDet) begin
            monoCnt <= MONO_LOAD;
            if (riseDet) begin
              if (riseCnt == LAST_RISE) state <= ST_DONE;
              else riseCnt <= riseCnt + 1'b1;
            end
          end else if (monoZero) begin
            state <= ST_ARMED;
          end else begin
            monoCnt <= monoCnt - 1'b1;
          end
        end
        ST_DONE: begin
          if (edgeDet) monoCnt <= MONO_LOAD;
          else if (monoZero) state <= ST_ARMED;
          else monoCnt <= monoCnt - 1'b1;
        end
        default: state <= ST_ARMED;
      endcase
    end
  end

  always_comb begin
    strb.latch = (state == ST_ARMED) && fallDet;
    strb.shift = (state == ST_SHIFT) && riseDet && (riseCnt != LAST_RISE);
    strb.park  = (state == ST_SHIFT) && riseDet && (riseCnt == LAST_RISE);
    strb.rearm = (state != ST_ARMED) && !edgeDet && monoZero;
  end

  assign armed = (state == ST_ARMED);
  assign done  = (state == ST_DONE);

endmodule

// File: rtl/ssi_tx_dpath.sv
module ssi_tx_dpath
  import ssi_tx_pkg::*;
#(
  parameter int WORD_W    = 25,
  parameter bit HOLD_LAST = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssiStrb_t          strb,
  input  logic [WORD_W-1:0] posWord,
  output logic              dataOut
);

  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      dataOut <= 1'b1;
    end else begin
      if (strb.latch) begin
        shReg <= posWord;
      end else if (strb.shift) begin
        dataOut <= shReg[WORD_W-1];
        shReg   <= {shReg[WORD_W-2:0], 1'b0};
      end else if (strb.park) begin
        if (!HOLD_LAST) dataOut <= 1'b0;
      end else if (strb.rearm) begin
        dataOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssi_tx.sv
module ssi_tx
  import ssi_tx_pkg::*;
#(
  parameter int WORD_W    = 25,
  parameter int MONO_CYC  = 4000,
  parameter bit HOLD_LAST = 1'b0,
  localparam int MONO_W   = $clog2(MONO_CYC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlClkIn,
  input  logic [WORD_W-1:0] posWord,
  output logic              dataOut
);

  logic              riseDet;
  logic              fallDet;
  logic              armed;
  logic              done;
  logic [MONO_W-1:0] monoCnt;
  ssiStrb_t          strb;

  ssi_tx_sync u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (ctrlClkIn),
    .riseDet (riseDet),
    .fallDet (fallDet)
  );

  ssi_tx_ctrl #(
    .WORD_W   (WORD_W),
    .MONO_CYC (MONO_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .riseDet (riseDet),
    .fallDet (fallDet),
    .strb    (strb),
    .armed   (armed),
    .done    (done),
    .monoCnt (monoCnt)
  );

  ssi_tx_dpath #(
    .WORD_W    (WORD_W),
    .HOLD_LAST (HOLD_LAST)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .posWord (posWord),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/ssi_tx_chk.sv
module ssi_tx_chk
  import ssi_tx_pkg::*;
#(
  parameter int WORD_W    = 25,
  parameter int MONO_CYC  = 4000,
  parameter bit HOLD_LAST = 1'b0,
  localparam int MONO_W   = $clog2(MONO_CYC)
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataOut,
  input logic              riseDet,
  input logic              fallDet,
  input logic              armed,
  input logic              done,
  input ssiStrb_t          strb,
  input logic [MONO_W-1:0] monoCnt
);

  // R1: an armed block keeps the line high
  a_r1_armed_line_high: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> dataOut);

  // R2: capturing the word does not disturb the line
  a_r2_latch_line_high: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |=> dataOut);

  // R3: the line moves only after a detected rise or on re-arm
  a_r3_change_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut != $past(dataOut)) |-> ($past(riseDet) || $past(strb.rearm)));

  // R4: end-of-frame line value
  a_r4_park_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.park |=> (HOLD_LAST ? $stable(dataOut) : !dataOut));

  // R5: any edge inside a frame reloads the timer and keeps the frame alive
  a_r5_edge_reload: assert property (@(posedge clk) disable iff (!rstN)
    ((riseDet || fallDet) && !armed) |=> (!armed && monoCnt == MONO_W'(MONO_CYC - 1)));

  // R6: expiry re-arms and raises the line
  a_r6_expiry_rearms: assert property (@(posedge clk) disable iff (!rstN)
    strb.rearm |=> (armed && dataOut));

  // R7: a falling edge after the frame has ended starts nothing
  a_r7_done_no_frame: assert property (@(posedge clk) disable iff (!rstN)
    (done && fallDet) |=> (!armed && $stable(dataOut)));

endmodule

bind ssi_tx ssi_tx_chk #(
  .WORD_W    (WORD_W),
  .MONO_CYC  (MONO_CYC),
  .HOLD_LAST (HOLD_LAST)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .dataOut (dataOut),
  .riseDet (riseDet),
  .fallDet (fallDet),
  .armed   (armed),
  .done    (done),
  .strb    (strb),
  .monoCnt (monoCnt)
);

// File: tb/ssi_tx_tb.sv
`timescale 1ns/1ps
module ssi_tx_tb;

  localparam int W    = 25;
  localparam int MONO = 40;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlPin = 1'b1;
  logic [W-1:0] posWord = '0;
  logic outA;
  logic outB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ssi_tx #(.WORD_W(W), .MONO_CYC(MONO), .HOLD_LAST(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlClkIn(ctrlPin), .posWord(posWord), .dataOut(outA));

  ssi_tx #(.WORD_W(W), .MONO_CYC(MONO), .HOLD_LAST(1'b1)) u_dutHold (
    .clk(clk), .rstN(rstN), .ctrlClkIn(ctrlPin), .posWord(posWord), .dataOut(outB));

  // behavioural reference: pin history, frame phase, idle cycle count
  bit h0 = 1, h1 = 1, h2 = 1;
  int mPhase = 0;
  int idleCyc = 0;
  int rises = 0;
  logic [W-1:0] mWord = '0;
  logic expA = 1'b1;
  logic expB = 1'b1;

  always @(posedge clk) begin
    bit r, f;
    if (!rstN) begin
      h0 = 1; h1 = 1; h2 = 1;
      mPhase = 0; idleCyc = 0; rises = 0;
      expA = 1'b1; expB = 1'b1;
    end else begin
      r = h1 && !h2;
      f = !h1 && h2;
      if (mPhase == 0) begin
        if (f) begin
          mPhase = 1; mWord = posWord; rises = 0; idleCyc = 0;
        end
      end else begin
        if (r || f) begin
          idleCyc = 0;
          if (r && mPhase == 1) begin
            if (rises < W) begin
              expA = mWord[W-1-rises];
              expB = mWord[W-1-rises];
              rises++;
            end else begin
              mPhase = 2;
              expA = 1'b0;
            end
          end
        end else if (idleCyc == MONO - 1) begin
          mPhase = 0; expA = 1'b1; expB = 1'b1;
        end else begin
          idleCyc++;
        end
      end
      h2 = h1; h1 = h0; h0 = ctrlPin;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      string tag;
      tag = (mPhase == 0) ? "R1" : (mPhase == 1) ? "R3" : "R4";
      check(outA === expA, {tag, " cycle compare drive-low"}, 32'(outA), 32'(expA));
      check(outB === expB, {tag, " cycle compare hold-last"}, 32'(outB), 32'(expB));
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full frame; high phase after rise gapAt lasts gapLen cycles
  task automatic runFrame(input logic [W-1:0] w, input int gapAt, input int gapLen,
                          output logic [W-1:0] gotA, output logic [W-1:0] gotB);
    posWord = w;
    ctrlPin = 1'b0;
    waitN(HALF);
    posWord = ~w;
    for (int k = 1; k <= W; k++) begin
      ctrlPin = 1'b1;
      waitN((k == gapAt) ? gapLen : HALF);
      gotA[W-k] = outA;
      gotB[W-k] = outB;
      ctrlPin = 1'b0;
      waitN(HALF);
    end
    ctrlPin = 1'b1;
    waitN(HALF);
  endtask

  task automatic frameAndCheck(input logic [W-1:0] w, input int gapAt, input int gapLen, input string tag);
    logic [W-1:0] gA, gB;
    runFrame(w, gapAt, gapLen, gA, gB);
    check(gA == w, {tag, " R3 R2 word drive-low"}, 32'(gA), 32'(w));
    check(gB == w, {tag, " R3 R2 word hold-last"}, 32'(gB), 32'(w));
    check(outA == 1'b0, {tag, " R4 park low"}, 32'(outA), 32'd0);
    check(outB == w[0], {tag, " R4 park hold"}, 32'(outB), 32'(w[0]));
    waitN(MONO + 10);
    check(outA && outB, {tag, " R8 rearm high"}, {30'd0, outA, outB}, 32'd3);
  endtask

  initial begin
    waitN(3);
    check(outA === 1'b1 && outB === 1'b1, "R1 reset level", {30'd0, outA, outB}, 32'd3);
    rstN = 1'b1;
    waitN(10);
    check(outA && outB, "R1 idle level", {30'd0, outA, outB}, 32'd3);

    frameAndCheck(25'h1555555, 0, HALF, "alt-a");
    frameAndCheck(25'h0AAAAAA, 0, HALF, "alt-b");
    frameAndCheck(25'h1FFFFFF, 0, HALF, "ones");
    frameAndCheck(25'h1000001, 0, HALF, "ends");
    frameAndCheck(25'h0000000, 0, HALF, "zero");

    // R5: one half-period just under the timer period
    frameAndCheck(25'h0F0F0F3, 10, MONO - 2, "R5 stretch");

    // R6: stall mid-frame beyond the timer period
    posWord = 25'h1234567;
    ctrlPin = 1'b0;
    waitN(HALF);
    for (int k = 0; k < 6; k++) begin
      ctrlPin = 1'b1; waitN(HALF);
      ctrlPin = 1'b0; waitN(HALF);
    end
    ctrlPin = 1'b1;
    waitN(MONO + 10);
    check(outA && outB, "R6 abort line high", {30'd0, outA, outB}, 32'd3);
    frameAndCheck(25'h0765432, 0, HALF, "R6 fresh");

    // R7: pulses after the frame end, before expiry
    begin
      logic [W-1:0] gA, gB;
      runFrame(25'h1555555, 0, HALF, gA, gB);
      posWord = 25'h0333333;
      for (int k = 0; k < 2; k++) begin
        ctrlPin = 1'b0; waitN(HALF);
        ctrlPin = 1'b1; waitN(HALF);
      end
      check(outA == 1'b0, "R7 no new frame drive-low", 32'(outA), 32'd0);
      check(outB == 1'b1, "R7 no new frame hold-last", 32'(outB), 32'd1);
      waitN(MONO - 12);
      check(outA == 1'b0, "R7 retrigger extends park", 32'(outA), 32'd0);
      waitN(20);
      check(outA && outB, "R8 rearm after pulses", {30'd0, outA, outB}, 32'd3);
    end
    frameAndCheck(25'h0333333, 0, HALF, "R8 next");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule